// File: doc/BRIEF.md
# Programmable Synchronous Clock Divider

This block divides a fast input clock by a programmable ratio N. It emits a one-cycle `tick` once every N input cycles. It also provides `div_clk`, a divided clock whose duty cycle is as close to half as an integer split allows. Downstream logic can use `tick` as a clock enable, or use `div_clk` as a slow square wave.

The counter never clears on an asynchronously decoded state. The end of each period is decoded one state early and held in a register. That register then drives the synchronous load on the next edge, so the decoder sits outside the reload path.

Two counting directions share the same output timing:
- **Down mode:** the counter is preset and decrements.
- **Up mode:** the counter starts from zero. A registered carry-like flag marks the last count and clears the counter on the following edge.

Because the decode is early, a ratio below 2 cannot be honoured. Such a ratio is raised to 2 and reported on `n_illegal`. A new ratio or direction takes effect only at a reload, so the period in progress always runs to its end.

Top module: `sync_divn`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `tick`=0 and `div_clk`=0, and a new period starts at phase 0 using the ratio on `div_n` at that edge.
- R2: After `rst` is released, `tick` is first high after the (N-1)-th rising edge, so a consumer samples it high on the N-th edge.
- R3: With `up_mode`=0 (down counting), `tick` is high for exactly one cycle and recurs with an exact period of N cycles.
- R4: With `up_mode`=1 (up counting, terminal at count N-1), `tick` has the same single-cycle width and N-cycle period as in down mode.
- R5: A `div_n` value of 0 or 1 is treated as 2, and the combinational output `n_illegal` is 1 exactly when `div_n` < 2.
- R6: `div_n` and `up_mode` are captured only at the edge that ends a period (the edge at which `tick` is high) or during reset; changes at any other time do not alter the period in progress.
- R7: Within each period, `div_clk` is 0 for the first floor(N/2) cycles and 1 for the remaining ceil(N/2) cycles, so it falls on the edge where `tick` ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_n | input | W (8) | Division ratio N, unsigned |
| up_mode | input | 1 | 0 = down counting, 1 = up counting |
| tick | output | 1 | One-cycle pulse in the last cycle of each period |
| div_clk | output | 1 | Divided clock, high in the second part of each period |
| n_illegal | output | 1 | Asserted while `div_n` is below 2 |

## Verification
The assertions assume that `rst` is held for at least one edge before any output is relied on. They also assume that `div_n` and `up_mode` are stable around the rising edge, so each reload captures one clean value.

The bench changes these inputs only on the falling edge. It holds reset for several cycles at start-up, and it pulses reset mid-period at random times.

Stimulus deliberately covers several cases:
- ratios of 0 and 1, which must be clamped;
- ratio and direction changes at arbitrary phases, which must wait for the next reload;
- the smallest legal ratio, 2, where `tick` and `div_clk` alternate every cycle.

// File: rtl/divn_pkg.sv
package divn_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Early decode needs at least two states per period
    localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/divn_limit.sv
module divn_limit
    import divn_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] ratio_i,
    output logic [W-1:0] ratio_o,
    output logic         illegal_o
);

    localparam logic [W-1:0] FLOOR_VAL = W'(MIN_RATIO);

    always_comb begin
        illegal_o = (ratio_i < FLOOR_VAL);
        ratio_o   = illegal_o ? FLOOR_VAL : ratio_i;
    end

endmodule

// File: rtl/divn_counter.sv
module divn_counter
    import divn_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_i,
    input  dir_e         dir_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] ratio_o,
    output dir_e         dir_o,
    output logic         term_o
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] ratio;
        dir_e         dir;
        logic         term;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || st_q.term) begin
            // synchronous preset: capture new ratio and direction
            st_d.ratio = ratio_i;
            st_d.dir   = dir_i;
            st_d.cnt   = (dir_i == DIR_UP) ? '0 : (ratio_i - ONE);
        end else if (st_q.dir == DIR_UP) begin
            st_d.cnt = st_q.cnt + ONE;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
        // decode one state ahead of the terminal state
        if (rst) begin
            st_d.term = 1'b0;
        end else if (st_q.dir == DIR_UP) begin
            st_d.term = (st_q.cnt == (st_q.ratio - TWO));
        end else begin
            st_d.term = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
    assign dir_o   = st_q.dir;
    assign term_o  = st_q.term;

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        st_q.ratio >= TWO);                                            // R5
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < st_q.ratio);                                        // R3
    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        st_q.term |=> !st_q.term);                                     // R3
    AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
        st_q.term |=> ((st_q.dir == DIR_UP) ? (st_q.cnt == '0)
                                             : (st_q.cnt == st_q.ratio - ONE))); // R4
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
        !st_q.term |=> ($stable(st_q.ratio) && $stable(st_q.dir)));    // R6

endmodule

// File: rtl/divn_duty.sv
module divn_duty
    import divn_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] ratio_i,
    input  dir_e         dir_i,
    input  logic         term_i,
    output logic         div_clk_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic lvl;
    } st_t;

    st_t  st_d, st_q;
    logic half_hit;

    always_comb begin
        // next cycle is phase floor(N/2)
        if (dir_i == DIR_UP) begin
            half_hit = ((cnt_i + ONE) == (ratio_i >> 1));
        end else begin
            half_hit = (cnt_i == (ratio_i - (ratio_i >> 1)));
        end
        st_d = st_q;
        if (rst || term_i) begin
            st_d.lvl = 1'b0;
        end else if (half_hit) begin
            st_d.lvl = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign div_clk_o = st_q.lvl;

    AST_DUTY_DROP: assert property (@(posedge clk) disable iff (rst)
        term_i |=> !st_q.lvl);                                         // R7
    AST_DUTY_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q.lvl && !term_i) |=> st_q.lvl);                           // R7

endmodule

// File: rtl/sync_divn.sv
module sync_divn
    import divn_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div_n,
    input  logic         up_mode,
    output logic         tick,
    output logic         div_clk,
    output logic         n_illegal
);

    logic [W-1:0] ratio_safe;
    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_q;
    dir_e         dir_q;
    logic         term_q;

    divn_limit #(.W(W)) u_limit (
        .ratio_i   (div_n),
        .ratio_o   (ratio_safe),
        .illegal_o (n_illegal)
    );

    divn_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (ratio_safe),
        .dir_i   (dir_e'(up_mode)),
        .cnt_o   (cnt_q),
        .ratio_o (ratio_q),
        .dir_o   (dir_q),
        .term_o  (term_q)
    );

    divn_duty #(.W(W)) u_duty (
        .clk       (clk),
        .rst       (rst),
        .cnt_i     (cnt_q),
        .ratio_i   (ratio_q),
        .dir_i     (dir_q),
        .term_i    (term_q),
        .div_clk_o (div_clk)
    );

    assign tick = term_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tick && !div_clk));                                  // R1

endmodule

// File: tb/tb_sync_divn.sv
module tb_sync_divn;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] div_n = 8'd5;
    logic         up_mode = 1'b0;
    logic         tick, div_clk, n_illegal;

    int n_checks = 0;
    int n_err    = 0;
    int m_phase  = 0;
    int m_n      = 2;
    int cyc      = 0;
    bit done     = 0;
    string cur_tag = "R1";

    sync_divn #(.W(W)) dut (
        .clk(clk), .rst(rst), .div_n(div_n), .up_mode(up_mode),
        .tick(tick), .div_clk(div_clk), .n_illegal(n_illegal)
    );

    always #5 clk = ~clk;

    function automatic int clamp_n(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic logic exp_tick();
        return logic'(m_phase == m_n - 1);
    endfunction

    function automatic logic exp_div();
        return logic'(m_phase >= m_n / 2);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d, N=%0d, phase=%0d)",
                     tag, what, act, exp, cyc, m_n, m_phase);
        end
    endtask

    // one input cycle: step the model with the inputs seen at the edge, then check
    task automatic step();
        @(negedge clk);
        cyc++;
        if (rst) begin
            m_phase = 0;
            m_n = clamp_n(int'(div_n));
        end else if (m_phase == m_n - 1) begin
            m_phase = 0;
            m_n = clamp_n(int'(div_n));
        end else begin
            m_phase++;
        end
        chk(rst ? "R1" : cur_tag, "tick", tick, exp_tick());
        chk("R7", "div_clk", div_clk, exp_div());
        chk("R5", "n_illegal", n_illegal, logic'(div_n < 2));
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int first_tick;
        void'($urandom(32'h1d2c3b4a));

        // R1: reset state
        cur_tag = "R1";
        run(3);

        // R2: first pulse timing after release, N=5
        @(negedge clk);
        rst = 1'b0;
        cur_tag = "R2";
        first_tick = 0;
        for (int i = 1; i <= 8; i++) begin
            step();
            if (tick && first_tick == 0) first_tick = i;
        end
        chk("R2", "first tick edge", logic'(first_tick == 4), 1'b1);

        // R3: down mode, a few fixed ratios including the minimum
        cur_tag = "R3";
        div_n = 8'd2;  run(12);
        div_n = 8'd7;  run(30);
        div_n = 8'd255; run(520);

        // R4: up mode
        cur_tag = "R4";
        up_mode = 1'b1;
        div_n = 8'd3;  run(15);
        div_n = 8'd2;  run(10);
        div_n = 8'd9;  run(40);

        // R5: illegal ratios clamp to 2
        cur_tag = "R5";
        div_n = 8'd0;  run(10);
        up_mode = 1'b0;
        div_n = 8'd1;  run(10);

        // R6: mid-period change waits for the reload
        cur_tag = "R6";
        div_n = 8'd10; run(12);
        div_n = 8'd3;  up_mode = 1'b1; run(4);
        div_n = 8'd6;  run(20);

        // R1: reset in the middle of a period
        cur_tag = "R1";
        div_n = 8'd11; run(5);
        rst = 1'b1; run(2);
        rst = 1'b0; cur_tag = "R2"; run(14);

        // random mix of ratios, modes, mid-period changes and resets
        for (int seg = 0; seg < 60; seg++) begin
            int len;
            cur_tag = up_mode ? "R4" : "R3";
            div_n   = W'($urandom % 24);
            up_mode = logic'($urandom % 2);
            len     = 1 + int'($urandom % 40);
            if ($urandom % 5 == 0) begin
                rst = 1'b1; run(1);
                rst = 1'b0;
            end
            for (int i = 0; i < len; i++) begin
                if ($urandom % 8 == 0) begin
                    cur_tag = "R6";
                    div_n = W'($urandom % 24);
                    up_mode = logic'($urandom % 2);
                end
                step();
            end
        end

        finish_up();
    end

endmodule